// File: doc/BRIEF.md
# Sectioned Memory Address Translator

This block sits between the L2 request arbiter and the on-chip interconnect and rewrites every core-visible address into an interconnect physical address. It holds a small number of programmable memory sections. Each section has a base, a mask and a physical base. A request address belongs to a section when its bits outside the mask equal that section's base. The translated address keeps the address bits under the mask and takes the remaining bits from the section's physical base.

The section registers cannot be written directly. The block snoops the committed map-update broadcast bus. It captures only the words addressed to its own section fields and ignores everything else on that bus. Staging several field writes and committing them together is the broadcaster's job, so each broadcast word the block sees is already a committed value.

The translate path is a parameterised variant. It is either purely combinational or registered through one pipeline stage, and one stage is the default.

Top module: `mm_addr_xlat`

## Requirements
- R1: A broadcast with `upd_valid` high loads `upd_data` into one section field. The field lives at update address 0x7A0 + 4*s + f, where s is the section number (0..3) and f selects the field: 0 is the base, 1 is the mask and 2 is the physical base.
- R2: A request address hits section s when (address AND NOT mask_s) equals base_s.
- R3: On a hit, the response address equals (address AND mask) OR physical base of the winning section, and `rsp_sec` gives that section number.
- R4: A section whose mask is zero never hits, whatever its base holds.
- R5: When no section hits, `rsp_hit` is 0, `rsp_sec` is 0 and `rsp_addr` equals the request address unchanged.
- R6: When more than one section hits, the lowest-numbered section supplies the result.
- R7: After reset, section 0 holds the parameter values INIT_BASE, INIT_MASK and INIT_PHYS. All other fields are zero, so those sections are disabled. `rsp_valid` is 0.
- R8: The section registers stay unchanged in three cases: `upd_valid` is low; the update address lies outside 0x7A0..0x7AF; or the update address selects field 3 of a section.
- R9: With PIPE=1, `rsp_valid`, `rsp_hit`, `rsp_sec` and `rsp_addr` present the result for the request sampled at the previous rising edge. `rsp_valid` equals the previous cycle's `req_valid`.
- R10: A request in the same cycle as a broadcast is translated with the section values as they stood before that broadcast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_valid | input | 1 | Committed map-update word present |
| upd_addr | input | 12 | Register address of the update word |
| upd_data | input | 32 | Update value |
| req_valid | input | 1 | Translation request present |
| req_addr | input | 32 | Core-visible address |
| rsp_valid | output | 1 | Translation result present |
| rsp_hit | output | 1 | 1 when a section matched, 0 for pass-through |
| rsp_sec | output | 2 | Number of the matching section |
| rsp_addr | output | 32 | Translated or passed-through address |

## Verification
The bench targets the following corner cases:

- **Disabled section.** A section with mask zero is given a base equal to the request address. A design that leaves out the zero-mask test would report a hit and splice in that section's physical base.
- **Overlapping sections.** Two sections are made to overlap. The bench checks that the lower-numbered one wins, and that the higher one takes over once the lower one is disabled. Reversed priority, or an OR of both results, shows up as a wrong section number or a corrupted address.
- **Mask boundaries.** Addresses at the top and just past the top of a section's window are translated. An off-by-one in the compare turns the hit into a miss, or the miss into a hit.
- **Update handling.** Stray broadcast addresses, the unused fourth field slot, an idle bus carrying a valid-looking address, a request in the same cycle as an update, and a soft reset are all checked. Each one catches a decoder that is too loose, a bypass path, or reset values that are not restored.

// File: rtl/mm_xlat_pkg.sv
package mm_xlat_pkg;
    localparam int unsigned ADDR_W     = 32;
    localparam int unsigned NUM_SEC    = 4;
    localparam int unsigned SEC_W      = (NUM_SEC > 1) ? $clog2(NUM_SEC) : 1;
    localparam int unsigned UPD_AW     = 12;
    localparam int unsigned MAP_ORIGIN = 12'h7A0;
    localparam int unsigned SEC_STRIDE = 4;
    localparam int unsigned MAP_END    = MAP_ORIGIN + SEC_STRIDE * NUM_SEC;

    typedef enum logic [1:0] {
        FLD_BASE = 2'd0,
        FLD_MASK = 2'd1,
        FLD_PHYS = 2'd2
    } fld_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] mask;
        logic [ADDR_W-1:0] phys;
    } sec_t;

    typedef struct packed {
        logic              valid;
        logic              hit;
        logic [SEC_W-1:0]  sec;
        logic [ADDR_W-1:0] addr;
    } rsp_t;

    function automatic logic [UPD_AW-1:0] fld_addr(input int unsigned s, input fld_e f);
        return UPD_AW'(MAP_ORIGIN + SEC_STRIDE * s + int'(f));
    endfunction
endpackage

// File: rtl/mm_sec_regs.sv
module mm_sec_regs
    import mm_xlat_pkg::*;
#(
    parameter logic [ADDR_W-1:0] INIT_BASE = '0,
    parameter logic [ADDR_W-1:0] INIT_MASK = '0,
    parameter logic [ADDR_W-1:0] INIT_PHYS = '0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    upd_valid,
    input  logic [UPD_AW-1:0]       upd_addr,
    input  logic [ADDR_W-1:0]       upd_data,
    output sec_t [NUM_SEC-1:0]      secs
);
    for (genvar s = 0; s < NUM_SEC; s++) begin : g_sec
        localparam sec_t RST_VAL = (s == 0) ? sec_t'{INIT_BASE, INIT_MASK, INIT_PHYS} : sec_t'('0);
        sec_t q;

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= RST_VAL;
            end else if (upd_valid) begin
                if (upd_addr == fld_addr(s, FLD_BASE)) q.base <= upd_data;
                if (upd_addr == fld_addr(s, FLD_MASK)) q.mask <= upd_data;
                if (upd_addr == fld_addr(s, FLD_PHYS)) q.phys <= upd_data;
            end
        end

        assign secs[s] = q;
    end

    // Words that address no section field must leave the map untouched.
    logic in_window;
    assign in_window = (32'(upd_addr) >= MAP_ORIGIN) && (32'(upd_addr) < MAP_END)
                       && (upd_addr[1:0] != 2'd3);

    assert_no_stray_load_R8: assert property (@(posedge clk) disable iff (rst)
        !(upd_valid && in_window) |=> $stable(secs));
endmodule

// File: rtl/mm_sec_match.sv
module mm_sec_match
    import mm_xlat_pkg::*;
(
    input  sec_t              sec,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [ADDR_W-1:0] xaddr
);
    logic enabled;
    assign enabled = |sec.mask;
    assign hit     = enabled && ((addr & ~sec.mask) == sec.base);
    assign xaddr   = (addr & sec.mask) | sec.phys;
endmodule

// File: rtl/mm_sec_pick.sv
module mm_sec_pick
    import mm_xlat_pkg::*;
(
    input  logic [NUM_SEC-1:0]             hits,
    input  logic [NUM_SEC-1:0][ADDR_W-1:0] xaddrs,
    input  logic [ADDR_W-1:0]              raw_addr,
    output logic                           any_hit,
    output logic [SEC_W-1:0]               win_sec,
    output logic [ADDR_W-1:0]              out_addr
);
    always_comb begin
        any_hit  = 1'b0;
        win_sec  = '0;
        out_addr = raw_addr;
        // Walk from the top down so the lowest matching section is the last writer.
        for (int i = NUM_SEC - 1; i >= 0; i--) begin
            if (hits[i]) begin
                any_hit  = 1'b1;
                win_sec  = SEC_W'(i);
                out_addr = xaddrs[i];
            end
        end
    end
endmodule

// File: rtl/mm_addr_xlat.sv
module mm_addr_xlat
    import mm_xlat_pkg::*;
#(
    parameter logic [ADDR_W-1:0] INIT_BASE = 32'h0000_0000,
    parameter logic [ADDR_W-1:0] INIT_MASK = 32'h000F_FFFF,
    parameter logic [ADDR_W-1:0] INIT_PHYS = 32'h4000_0000,
    parameter bit                PIPE      = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_valid,
    input  logic [11:0]       upd_addr,
    input  logic [31:0]       upd_data,
    input  logic              req_valid,
    input  logic [31:0]       req_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [1:0]        rsp_sec,
    output logic [31:0]       rsp_addr
);
    sec_t [NUM_SEC-1:0]             secs;
    logic [NUM_SEC-1:0]             hits;
    logic [NUM_SEC-1:0][ADDR_W-1:0] xaddrs;
    logic                           pick_hit;
    logic [SEC_W-1:0]               pick_sec;
    logic [ADDR_W-1:0]              pick_addr;
    rsp_t                           comb_rsp;
    rsp_t                           out_rsp;

    mm_sec_regs #(
        .INIT_BASE(INIT_BASE), .INIT_MASK(INIT_MASK), .INIT_PHYS(INIT_PHYS)
    ) u_regs (
        .clk(clk), .rst(rst), .upd_valid(upd_valid),
        .upd_addr(upd_addr), .upd_data(upd_data), .secs(secs)
    );

    for (genvar s = 0; s < NUM_SEC; s++) begin : g_match
        mm_sec_match u_match (
            .sec(secs[s]), .addr(req_addr), .hit(hits[s]), .xaddr(xaddrs[s])
        );

        // A zero mask must keep this section silent.
        assert_zero_mask_silent_R4: assert property (@(posedge clk) disable iff (rst)
            (secs[s].mask == '0) |-> !hits[s]);

        // No higher-numbered section may win over this one.
        assert_low_section_wins_R6: assert property (@(posedge clk) disable iff (rst)
            hits[s] |-> (pick_hit && (32'(pick_sec) <= s)));
    end

    mm_sec_pick u_pick (
        .hits(hits), .xaddrs(xaddrs), .raw_addr(req_addr),
        .any_hit(pick_hit), .win_sec(pick_sec), .out_addr(pick_addr)
    );

    assign comb_rsp = '{valid: req_valid, hit: pick_hit, sec: pick_sec, addr: pick_addr};

    if (PIPE) begin : g_pipe
        always_ff @(posedge clk) begin
            if (rst) out_rsp <= '0;
            else     out_rsp <= comb_rsp;
        end

        assert_rsp_follows_req_R9: assert property (@(posedge clk) disable iff (rst)
            req_valid |=> rsp_valid);
        assert_no_spurious_rsp_R9: assert property (@(posedge clk) disable iff (rst)
            !req_valid |=> !rsp_valid);
        assert_miss_passthrough_R5: assert property (@(posedge clk) disable iff (rst)
            (req_valid && !(|hits)) |=> (!rsp_hit && rsp_addr == $past(req_addr)));
    end else begin : g_comb
        assign out_rsp = comb_rsp;

        assert_miss_passthrough_R5: assert property (@(posedge clk) disable iff (rst)
            (req_valid && !(|hits)) |-> (!rsp_hit && rsp_addr == req_addr));
    end

    assign rsp_valid = out_rsp.valid;
    assign rsp_hit   = out_rsp.hit;
    assign rsp_sec   = out_rsp.sec;
    assign rsp_addr  = out_rsp.addr;
endmodule

// File: tb/test_mm_addr_xlat.sv
`timescale 1ns/1ps
module test_mm_addr_xlat;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        upd_valid = 1'b0;
    logic [11:0] upd_addr = '0;
    logic [31:0] upd_data = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        rsp_valid, rsp_hit;
    logic [1:0]  rsp_sec;
    logic [31:0] rsp_addr;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    mm_addr_xlat i_mm_addr_xlat (
        .clk(clk), .rst(rst), .upd_valid(upd_valid), .upd_addr(upd_addr),
        .upd_data(upd_data), .req_valid(req_valid), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_sec(rsp_sec), .rsp_addr(rsp_addr)
    );

    task automatic expect_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One committed broadcast word; starts and ends at a falling edge.
    task automatic put(input logic [11:0] a, input logic [31:0] d);
        upd_valid = 1'b1; upd_addr = a; upd_data = d;
        @(negedge clk);
        upd_valid = 1'b0; upd_addr = '0; upd_data = '0;
    endtask

    // One request; result sampled at the next falling edge (one register stage).
    task automatic xlat(input logic [31:0] a, input logic [31:0] exp_addr,
                        input logic exp_hit, input logic [1:0] exp_sec, input string tag);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        expect_eq({tag, " valid"}, 32'(rsp_valid), 32'd1);
        expect_eq({tag, " hit"},   32'(rsp_hit),   32'(exp_hit));
        expect_eq({tag, " sec"},   32'(rsp_sec),   32'(exp_sec));
        expect_eq({tag, " addr"},  rsp_addr,       exp_addr);
    endtask

    task automatic t_reset_state;
        expect_eq("R7 rsp_valid in reset", 32'(rsp_valid), 32'd0);
        @(negedge clk); rst = 1'b0;
        xlat(32'h0001_2345, 32'h4001_2345, 1'b1, 2'd0, "R7 R3 section0 init");
        xlat(32'h0010_0000, 32'h0010_0000, 1'b0, 2'd0, "R5 miss passthrough");
        xlat(32'h2000_1234, 32'h2000_1234, 1'b0, 2'd0, "R7 section1 disabled");
    endtask

    task automatic t_program;
        put(12'h7A4, 32'h2000_0000);
        put(12'h7A5, 32'h0000_FFFF);
        put(12'h7A6, 32'h9000_0000);
        xlat(32'h2000_1234, 32'h9000_1234, 1'b1, 2'd1, "R1 R3 section1 hit");
        xlat(32'h2000_FFFF, 32'h9000_FFFF, 1'b1, 2'd1, "R2 top of window");
        xlat(32'h2001_0000, 32'h2001_0000, 1'b0, 2'd0, "R2 past window");
    endtask

    task automatic t_disabled;
        put(12'h7A8, 32'h0010_0000);
        put(12'h7AA, 32'h5555_0000);
        xlat(32'h0010_0000, 32'h0010_0000, 1'b0, 2'd0, "R4 zero mask no hit");
        put(12'h7A9, 32'h0000_00FF);
        xlat(32'h0010_0042, 32'h5555_0042, 1'b1, 2'd2, "R1 section2 enabled");
    endtask

    task automatic t_priority;
        put(12'h7AC, 32'h2000_0000);
        put(12'h7AD, 32'h0000_0FFF);
        put(12'h7AE, 32'hA000_0000);
        xlat(32'h2000_0010, 32'h9000_0010, 1'b1, 2'd1, "R6 lower section wins");
        put(12'h7A5, 32'h0000_0000);
        xlat(32'h2000_0010, 32'hA000_0010, 1'b1, 2'd3, "R6 R4 higher after disable");
        put(12'h7A5, 32'h0000_FFFF);
        xlat(32'h2000_0010, 32'h9000_0010, 1'b1, 2'd1, "R6 restored");
    endtask

    task automatic t_ignore;
        put(12'h7A3, 32'hFFFF_FFFF);
        put(12'h7A7, 32'hFFFF_FFFF);
        put(12'h7AF, 32'hFFFF_FFFF);
        put(12'h7B0, 32'hFFFF_FFFF);
        put(12'h79F, 32'hFFFF_FFFF);
        put(12'h3A2, 32'h1234_0000);
        upd_valid = 1'b0; upd_addr = 12'h7A2; upd_data = 32'h1234_0000;
        @(negedge clk);
        upd_addr = 12'h7A6;
        @(negedge clk);
        upd_addr = '0; upd_data = '0;
        xlat(32'h0001_2345, 32'h4001_2345, 1'b1, 2'd0, "R8 section0 intact");
        xlat(32'h2000_1234, 32'h9000_1234, 1'b1, 2'd1, "R8 section1 intact");
    endtask

    task automatic t_same_cycle;
        upd_valid = 1'b1; upd_addr = 12'h7A6; upd_data = 32'hB000_0000;
        req_valid = 1'b1; req_addr = 32'h2000_1234;
        @(negedge clk);
        upd_valid = 1'b0; req_valid = 1'b0;
        expect_eq("R10 old value used", rsp_addr, 32'h9000_1234);
        xlat(32'h2000_1234, 32'hB000_1234, 1'b1, 2'd1, "R10 new value next");
    endtask

    task automatic t_latency;
        @(negedge clk);
        expect_eq("R9 idle no rsp", 32'(rsp_valid), 32'd0);
        req_valid = 1'b1; req_addr = 32'h0001_0000;
        @(negedge clk);
        expect_eq("R9 first of pair", rsp_addr, 32'h4001_0000);
        req_addr = 32'h2000_0002;
        @(negedge clk);
        req_valid = 1'b0;
        expect_eq("R9 second of pair", rsp_addr, 32'hB000_0002);
        expect_eq("R9 second valid", 32'(rsp_valid), 32'd1);
        @(negedge clk);
        expect_eq("R9 valid drops", 32'(rsp_valid), 32'd0);
    endtask

    task automatic t_soft_reset;
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        expect_eq("R7 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        rst = 1'b0;
        xlat(32'h2000_1234, 32'h2000_1234, 1'b0, 2'd0, "R7 section1 cleared");
        xlat(32'h0010_0042, 32'h0010_0042, 1'b0, 2'd0, "R7 section2 cleared");
        xlat(32'h000F_FFFF, 32'h400F_FFFF, 1'b1, 2'd0, "R7 section0 restored");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        t_program();
        t_disabled();
        t_priority();
        t_ignore();
        t_same_cycle();
        t_latency();
        t_soft_reset();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule